// File: doc/BRIEF.md
# Recursive Carry-Select Adder

A combinational binary adder of parameterised power-of-two width. Its delay grows with the logarithm of the width, not linearly. The operand range is split in half. The low half is added with the real carry-in. Two copies of the high half are added at the same time, one assuming an incoming carry of 0 and one assuming 1. When the low half's carry-out settles, a 2:1 multiplexer picks the right high result. The same split is applied again inside every half until the span reaches a small leaf width, where a plain ripple chain is cheaper than another level of selection.

Each span also produces a propagate flag (an incoming carry passes straight through) and a generate flag (the span makes a carry on its own). Adjacent spans combine these flags. The root pair is brought out so that a neighbouring adder can chain onto this one without waiting for its sum.

Top module: `rcs_adder`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^N for every input combination.
- R2: `cout` equals bit N of the (N+1)-bit value a + b + cin.
- R3: `cout` always equals `grp_g | (grp_p & cin)`, so the carry formed by the mux tree agrees with the carry implied by the exposed flags.
- R4: When a and b differ in every bit, the carry-in travels through all N positions: with cin=1 the sum is all zeros and cout=1; with cin=0 the sum is all ones and cout=0.
- R5: An all-ones operand plus one, whether the one comes from the other operand or from cin, gives sum zero and cout=1.
- R6: `grp_p` is 1 exactly when a[i] != b[i] for every bit i. `grp_g` is 1 exactly when a + b with no carry-in overflows N bits. The two are never both 1.
- R7: `grp_p` and `grp_g` do not depend on cin: applying the same a and b with cin=0 and then cin=1 gives identical flags.
- R8: All-zero inputs give sum 0, cout 0, grp_p 0 and grp_g 0.
- R9: The leaf-width parameter changes only the structure. An instance with N=8 and leaf width 4 meets R1, R2 and R6 on the low 8 bits of the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First addend |
| b | input | N | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum modulo 2^N |
| cout | output | 1 | Carry out of bit N-1 |
| grp_p | output | 1 | Whole-span propagate flag |
| grp_g | output | 1 | Whole-span generate flag |

## Verification
The bound checker re-evaluates four things whenever an input changes: the sum and carry against a behavioural addition, the agreement between the multiplexed carry and the one implied by the exposed flags, and the meaning and mutual exclusion of those flags. That cin leaves the flags untouched, the full-length propagate chains, and the wrap of an all-ones operand show up only in the bench's chosen sequences. The same holds for a second instance with a wider leaf and the bench's random traffic. Carries that cross every split boundary are driven on purpose, so a wrong select at any level of the recursion changes a visible result.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;

    // Propagate / generate summary of one contiguous bit span
    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // Join a lower span with the span directly above it
    function automatic pg_t pg_join(input pg_t lo, input pg_t hi);
        pg_t r;
        r.p = lo.p & hi.p;
        r.g = hi.g | (hi.p & lo.g);
        return r;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rcs_leaf.sv
`timescale 1ns/1ps
module rcs_leaf
    import rcs_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output pg_t          pg
);

    logic [W:0] chain;
    logic [W:0] gchain;

    // Short ripple chain: cheaper than another select level at this width
    always_comb begin
        chain[0]  = cin;
        gchain[0] = 1'b0;
        for (int i = 0; i < W; i++) begin
            sum[i]      = a[i] ^ b[i] ^ chain[i];
            chain[i+1]  = maj3(a[i], b[i], chain[i]);
            gchain[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & gchain[i]);
        end
        cout = chain[W];
        pg.p = &(a ^ b);
        pg.g = gchain[W];
    end

endmodule

// File: rtl/rcs_sel.sv
`timescale 1ns/1ps
module rcs_sel #(
    parameter int W = 2
) (
    input  logic         pick,
    input  logic [W-1:0] s_if0,
    input  logic [W-1:0] s_if1,
    input  logic         c_if0,
    input  logic         c_if1,
    output logic [W-1:0] s_out,
    output logic         c_out
);

    always_comb begin
        s_out = pick ? s_if1 : s_if0;
        c_out = pick ? c_if1 : c_if0;
    end

endmodule

// File: rtl/rcs_node.sv
`timescale 1ns/1ps
module rcs_node
    import rcs_pkg::*;
#(
    parameter int W    = 32,
    parameter int LEAF = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output pg_t          pg
);

    localparam int H = W / 2;

    generate
        if (W <= LEAF) begin : g_leaf
            rcs_leaf #(.W(W)) u_leaf (
                .a(a), .b(b), .cin(cin),
                .sum(sum), .cout(cout), .pg(pg)
            );
        end else begin : g_split
            logic [H-1:0] lo_sum, hi0_sum, hi1_sum, hi_sum;
            logic         lo_c, hi0_c, hi1_c;
            pg_t          lo_pg, hi0_pg, hi1_pg, hi_pg;

            rcs_node #(.W(H), .LEAF(LEAF)) u_lo (
                .a(a[H-1:0]), .b(b[H-1:0]), .cin(cin),
                .sum(lo_sum), .cout(lo_c), .pg(lo_pg)
            );
            rcs_node #(.W(H), .LEAF(LEAF)) u_hi0 (
                .a(a[W-1:H]), .b(b[W-1:H]), .cin(1'b0),
                .sum(hi0_sum), .cout(hi0_c), .pg(hi0_pg)
            );
            rcs_node #(.W(H), .LEAF(LEAF)) u_hi1 (
                .a(a[W-1:H]), .b(b[W-1:H]), .cin(1'b1),
                .sum(hi1_sum), .cout(hi1_c), .pg(hi1_pg)
            );

            rcs_sel #(.W(H)) u_sel (
                .pick(lo_c),
                .s_if0(hi0_sum), .s_if1(hi1_sum),
                .c_if0(hi0_c),   .c_if1(hi1_c),
                .s_out(hi_sum),  .c_out(cout)
            );

            // Both speculative copies hold the same flags; take one field
            // from each so neither copy carries the whole fanout
            always_comb begin
                hi_pg.p = hi1_pg.p;
                hi_pg.g = hi0_pg.g;
            end

            assign sum = {hi_sum, lo_sum};
            assign pg  = pg_join(lo_pg, hi_pg);
        end
    endgenerate

endmodule

// File: rtl/rcs_adder.sv
`timescale 1ns/1ps
module rcs_adder
    import rcs_pkg::*;
#(
    parameter int N    = 32,
    parameter int LEAF = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout,
    output logic         grp_p,
    output logic         grp_g
);

    generate
        if (!is_pow2(N) || N < 4 || !is_pow2(LEAF) || LEAF > N) begin : g_bad_cfg
            $error("rcs_adder: N must be a power of two >= 4, LEAF a power of two <= N");
        end
    endgenerate

    pg_t root_pg;

    rcs_node #(.W(N), .LEAF(LEAF)) u_root (
        .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .pg(root_pg)
    );

    assign grp_p = root_pg.p;
    assign grp_g = root_pg.g;

endmodule

// File: rtl/rcs_adder_chk.sv
`timescale 1ns/1ps
module rcs_adder_chk #(
    parameter int N = 32
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         cin,
    input logic [N-1:0] sum,
    input logic         cout,
    input logic         grp_p,
    input logic         grp_g
);

    logic [N:0] full_ref;
    logic [N:0] nocin_ref;

    assign full_ref  = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
    assign nocin_ref = {1'b0, a} + {1'b0, b};

    always_comb begin
        p_sum_r1: assert (sum == full_ref[N-1:0])
            else $error("p_sum_r1: sum mismatch");
        p_cout_r2: assert (cout == full_ref[N])
            else $error("p_cout_r2: carry-out mismatch");
        p_flags_cout_r3: assert (cout == (grp_g | (grp_p & cin)))
            else $error("p_flags_cout_r3: mux carry disagrees with flags");
        p_prop_r6: assert (grp_p == (&(a ^ b)))
            else $error("p_prop_r6: propagate flag wrong");
        p_gen_r6: assert (grp_g == nocin_ref[N])
            else $error("p_gen_r6: generate flag wrong");
        p_excl_r6: assert (!(grp_p && grp_g))
            else $error("p_excl_r6: propagate and generate both set");
    end

endmodule

bind rcs_adder rcs_adder_chk #(.N(N)) u_chk (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
    .grp_p(grp_p), .grp_g(grp_g)
);

// File: tb/sim_rcs_adder.sv
`timescale 1ns/1ps
module sim_rcs_adder;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] a = '0, b = '0;
    logic        cin = 1'b0;
    logic [31:0] sum;
    logic        cout, grp_p, grp_g;
    logic [7:0]  sum8;
    logic        cout8, grp_p8, grp_g8;

    rcs_adder #(.N(32), .LEAF(2)) u0 (
        .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
    );

    // R9: narrower instance with a wider ripple leaf
    rcs_adder #(.N(8), .LEAF(4)) u1 (
        .a(a[7:0]), .b(b[7:0]), .cin(cin),
        .sum(sum8), .cout(cout8), .grp_p(grp_p8), .grp_g(grp_g8)
    );

    typedef struct {
        logic [31:0] s;
        logic        c, p, g;
        logic [7:0]  s8;
        logic        c8, p8, g8;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    int n_chk = 0;
    logic prev_p, prev_g;

    task automatic drive(input logic [31:0] ta, input logic [31:0] tb,
                         input logic tc, input string tag);
        exp_t e;
        logic [32:0] f;
        logic [8:0]  f8;
        @(posedge clk);
        #1;
        a = ta; b = tb; cin = tc;
        f    = {1'b0, ta} + {1'b0, tb} + {32'd0, tc};
        e.s  = f[31:0];
        e.c  = f[32];
        e.p  = &(ta ^ tb);
        f    = {1'b0, ta} + {1'b0, tb};
        e.g  = f[32];
        f8   = {1'b0, ta[7:0]} + {1'b0, tb[7:0]} + {8'd0, tc};
        e.s8 = f8[7:0];
        e.c8 = f8[8];
        e.p8 = &(ta[7:0] ^ tb[7:0]);
        f8   = {1'b0, ta[7:0]} + {1'b0, tb[7:0]};
        e.g8 = f8[8];
        e.tag = tag;
        q.push_back(e);
        n_vec++;
    endtask

    task automatic cmp(input string what, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, expv);
        end
    endtask

    // Monitor: one expected item per driven vector, sampled mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp({e.tag, " u0 sum"},   sum,           e.s);
            cmp({e.tag, " u0 cout"},  {31'd0, cout},  {31'd0, e.c});
            cmp({e.tag, " u0 grp_p"}, {31'd0, grp_p}, {31'd0, e.p});
            cmp({e.tag, " u0 grp_g"}, {31'd0, grp_g}, {31'd0, e.g});
            cmp({"R9 (", e.tag, ") u1 sum"},   {24'd0, sum8},   {24'd0, e.s8});
            cmp({"R9 (", e.tag, ") u1 cout"},  {31'd0, cout8},  {31'd0, e.c8});
            cmp({"R9 (", e.tag, ") u1 flags"}, {30'd0, grp_p8, grp_g8},
                                               {30'd0, e.p8, e.g8});
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual still running, expected finished");
        summary();
    end

    initial begin
        logic [31:0] ra, rb;
        // R8: all-zero inputs
        drive(32'h0, 32'h0, 1'b0, "R8 zeros");
        // R5: all-ones plus one, both ways
        drive(32'hFFFF_FFFF, 32'h0, 1'b1, "R5 ones+cin");
        drive(32'hFFFF_FFFF, 32'h1, 1'b0, "R5 ones+b");
        drive(32'h1, 32'hFFFF_FFFF, 1'b0, "R5 b-ones");
        // R4: full propagate chains
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 alt cin1");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R4 alt cin0");
        drive(32'hFFFF_0000, 32'h0000_FFFF, 1'b1, "R4 halves cin1");
        for (int i = 0; i < 16; i++) begin
            ra = $urandom();
            drive(ra, ~ra, i[0], "R4 random complement");
        end
        // R3: carries crossing each split boundary
        drive(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R3 cross 16");
        drive(32'h00FF_00FF, 32'h0000_0001, 1'b0, "R3 cross 8");
        drive(32'h0F0F_0F0F, 32'h0000_0000, 1'b1, "R3 cross 4");
        drive(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, "R3 to msb");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 gen top");
        drive(32'h8000_0000, 32'h8000_0000, 1'b1, "R3 gen top cin");
        // R7: same operands with both carry-in values
        for (int i = 0; i < 40; i++) begin
            ra = $urandom();
            rb = (i < 20) ? ~ra : $urandom();
            drive(ra, rb, 1'b0, "R7 cin0");
            @(negedge clk);
            prev_p = grp_p;
            prev_g = grp_g;
            drive(ra, rb, 1'b1, "R7 cin1");
            @(negedge clk);
            #0.1;
            cmp("R7 grp_p unchanged by cin", {31'd0, grp_p}, {31'd0, prev_p});
            cmp("R7 grp_g unchanged by cin", {31'd0, grp_g}, {31'd0, prev_g});
        end
        // R1 / R2 / R6: random traffic
        for (int i = 0; i < 3000; i++) begin
            drive($urandom(), $urandom(), 1'($urandom()), "R1 R2 R6 random");
        end
        repeat (4) @(posedge clk);
        summary();
    end

endmodule